// File: doc/BRIEF.md
# Result Window Comparator with Consecutive-Match Counter

This block watches the stream of finished conversion results. Each result carries a channel number and a 12-bit unsigned value. Two independent comparator instances each pick one channel and test every result from that channel against a programmed threshold. The test is either "below the threshold" or "at or above the threshold". When the test has passed on a programmed number of consecutive results from that channel, the instance sets a sticky flag. Software clears the flag by writing a one to its bit.

Each instance is programmed through one configuration word, written through a per-instance strobe on a shared data bus. The word carries the enable, the condition, the match count, the channel and the threshold. Writing an all-zero word turns an instance off. The flags stay set until they are cleared, so an interrupt controller can sample them directly.

Top module: `res_window_cmp`

## Requirements
- R1: The configuration word packs its fields as follows: bit 0 enable, bit 1 condition, bits [5:2] match count minus one, bits [9:6] channel, bits [21:10] threshold. A strobe bit `cfg_wr[i]` loads `cfg_word` into instance i.
- R2: With condition 0 a result passes when its value is unsigned less than the threshold. With condition 1 it passes when the value is greater than or equal to the threshold. A value equal to the threshold therefore passes only with condition 1.
- R3: With a match-count field of M, the flag of an instance sets on the M+1-th consecutive passing result of its channel (1 to 16 results). The flag is visible on the clock edge that follows that result.
- R4: Results from other channels, and cycles with `res_valid` low, neither advance nor reset an instance's run count.
- R5: A result on the selected channel that fails the condition resets the run count to zero.
- R6: Once the flag sets, the run count restarts from zero. The flag stays set until it is cleared, and further passing results do not change it.
- R7: A one on `flag_clr[i]` clears flag i on the next edge, and a zero leaves the flag alone. If a set and a clear fall in the same cycle, the set wins.
- R8: While the enable bit is 0, for example after an all-zero word is written, the instance never counts and never sets its flag.
- R9: A configuration write resets that instance's run count to zero. The new settings apply to results from the next cycle on. A result arriving in the same cycle as the write is ignored by that instance.
- R10: The two instances are independent. Results, writes and clears aimed at one of them do not affect the other's flag or run count.
- R11: After reset both flags are 0 and both instances are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 12 | Unsigned result value |
| cfg_wr | input | 2 | Per-instance configuration write strobe |
| cfg_word | input | 22 | Configuration word shared by both instances |
| flag_clr | input | 2 | Write-one-to-clear for each flag |
| flag | output | 2 | Sticky match flag of each instance |

## Verification
The bench feeds runs of passing results that are interleaved with results on other channels and with idle cycles. These runs separate a counter that correctly ignores foreign channels from one that advances or restarts on them. Values sit exactly on the threshold and one below it, so an off-by-one in either condition shows up as a missing or an early flag. The longest run of sixteen is checked at fifteen and sixteen results. Failing results dropped into runs, rewrites in the middle of a run, and a set coinciding with a clear each test whether the count restarts at the right moment. Long random streams with occasional rewrites and clears cover interactions between the two instances.

// File: rtl/rwc_pkg.sv
// Shared widths and the configuration word layout for the result window comparator.
// Assumes results are unsigned and that channel numbers fit in CH_W bits.
package rwc_pkg;
    parameter int DATA_W = 12;
    parameter int CH_W   = 4;
    parameter int CNT_W  = 4;

    // Packed so that the enable lands in bit 0 and the threshold in the top bits.
    typedef struct packed {
        logic [DATA_W-1:0] thr;
        logic [CH_W-1:0]   chan;
        logic [CNT_W-1:0]  need_m1;
        logic              cond;
        logic              en;
    } rwc_cfg_t;

    localparam int CFG_W = $bits(rwc_cfg_t);
endpackage

// File: rtl/rwc_cfg_reg.sv
// Holds one instance's configuration word.
// Assumes: the write strobe is a single-cycle pulse; reset leaves the instance disabled.
module rwc_cfg_reg
    import rwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] word,
    output rwc_cfg_t         cfg
);
    // Load the word on a strobe; reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg <= '0;
        else if (wr) cfg <= rwc_cfg_t'(word);
    end
endmodule

// File: rtl/rwc_compare.sv
// Combinational threshold test for one result value.
// Assumes: both operands are unsigned, cond=0 selects below, cond=1 selects at-or-above.
module rwc_compare
    import rwc_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] thr,
    input  logic              cond,
    output logic              pass
);
    // Pick the relation named by the condition bit.
    always_comb begin
        if (cond) pass = (value >= thr);
        else      pass = (value <  thr);
    end
endmodule

// File: rtl/rwc_tracker.sv
// Counts consecutive passing results on the selected channel and owns the sticky flag.
// Assumes: a config write restarts the run and wins over a same-cycle result;
// a set wins over a same-cycle clear.
module rwc_tracker
    import rwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             sample,
    input  logic             pass,
    input  logic [CNT_W-1:0] need_m1,
    input  logic             clr,
    output logic             flag
);
    logic [CNT_W-1:0] run_cnt;
    logic             counts;
    logic             last_hit;
    logic             fire;

    // Decide whether this cycle's result counts and whether it closes the run.
    always_comb begin
        counts   = en && !restart && sample;
        last_hit = (run_cnt == need_m1);
        fire     = counts && pass && last_hit;
    end

    // Track the run length: restart on a write, a disable, a miss or a completed run.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en) run_cnt <= '0;
        else if (counts) begin
            if (!pass || last_hit) run_cnt <= '0;
            else                   run_cnt <= run_cnt + 1'b1;
        end
    end

    // Sticky flag: set on a completed run, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (fire) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/res_window_cmp.sv
// Top: NUM_CMP independent window comparators on one stream of tagged results.
// Assumes: at most one result per cycle; the configuration bus is shared and
// steered by per-instance strobes.
module res_window_cmp
    import rwc_pkg::*;
#(
    parameter int NUM_CMP = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid,
    input  logic [CH_W-1:0]       res_chan,
    input  logic [DATA_W-1:0]     res_data,
    input  logic [NUM_CMP-1:0]    cfg_wr,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic [NUM_CMP-1:0]    flag_clr,
    output logic [NUM_CMP-1:0]    flag
);
    logic [NUM_CMP-1:0]           cmp_en;
    logic [NUM_CMP-1:0][CH_W-1:0] cmp_chan;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        rwc_cfg_t cfg;
        logic     pass;
        logic     sample;

        rwc_cfg_reg u_cfg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (cfg_wr[i]),
            .word (cfg_word),
            .cfg  (cfg)
        );

        rwc_compare u_cmp (
            .value(res_data),
            .thr  (cfg.thr),
            .cond (cfg.cond),
            .pass (pass)
        );

        // A result is a candidate only when it belongs to this instance's channel.
        always_comb begin
            sample      = res_valid && (res_chan == cfg.chan);
            cmp_en[i]   = cfg.en;
            cmp_chan[i] = cfg.chan;
        end

        rwc_tracker u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (cfg.en),
            .restart(cfg_wr[i]),
            .sample (sample),
            .pass   (pass),
            .need_m1(cfg.need_m1),
            .clr    (flag_clr[i]),
            .flag   (flag[i])
        );
    end
endmodule

// File: rtl/res_window_cmp_checker.sv
// Temporal checks on the comparator flags; bound to the top module.
module res_window_cmp_checker
    import rwc_pkg::*;
#(
    parameter int NUM_CMP = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         res_valid,
    input logic [CH_W-1:0]              res_chan,
    input logic [NUM_CMP-1:0]           cfg_wr,
    input logic [NUM_CMP-1:0]           flag_clr,
    input logic [NUM_CMP-1:0]           flag,
    input logic [NUM_CMP-1:0]           cmp_en,
    input logic [NUM_CMP-1:0][CH_W-1:0] cmp_chan
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (flag == '0)); // R11

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flag[i] && !flag_clr[i] |=> flag[i]); // R6
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            flag[i] && flag_clr[i] && !res_valid |=> !flag[i]); // R7
        AST_SET_ON_OWN_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(res_valid && res_chan == cmp_chan[i])); // R4
        AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(cmp_en[i])); // R8
        AST_WRITE_BLOCKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> !$past(cfg_wr[i])); // R9
    end
endmodule

bind res_window_cmp res_window_cmp_checker #(.NUM_CMP(NUM_CMP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_valid(res_valid),
    .res_chan (res_chan),
    .cfg_wr   (cfg_wr),
    .flag_clr (flag_clr),
    .flag     (flag),
    .cmp_en   (cmp_en),
    .cmp_chan (cmp_chan)
);

// File: tb/test_res_window_cmp.sv
module test_res_window_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic [1:0]  cfg_wr = '0;
    logic [21:0] cfg_word = '0;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state per instance (R1 layout decoded from the word)
    bit        m_en[2];
    bit        m_cond[2];
    bit [3:0]  m_need[2];
    bit [3:0]  m_chan[2];
    bit [11:0] m_thr[2];
    int        m_cnt[2];
    bit        m_flag[2];

    res_window_cmp i_res_window_cmp (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .flag_clr(flag_clr), .flag(flag)
    );

    always #2 clk = ~clk;

    function automatic bit [21:0] mk_cfg(bit en, bit cond, int n, bit [3:0] ch, bit [11:0] thr);
        bit [3:0] nm1 = 4'(n - 1);
        return {thr, ch, nm1, cond, en};
    endfunction

    function automatic bit passes(bit cond, bit [11:0] v, bit [11:0] thr);
        return cond ? (v >= thr) : (v < thr);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_cond[i] = 0; m_need[i] = 0; m_chan[i] = 0;
            m_thr[i] = 0; m_cnt[i] = 0; m_flag[i] = 0;
        end
    endtask

    task automatic check_flags(string tag);
        for (int i = 0; i < 2; i++) begin
            n_chk++;
            if (flag[i] !== m_flag[i]) begin
                n_bad++;
                $display("FAIL %s: flag[%0d] actual %b expected %b at %0t", tag, i, flag[i], m_flag[i], $time);
            end
        end
    endtask

    // One cycle: drive on the falling edge, advance the model, compare after the rising edge.
    task automatic step(bit v, bit [3:0] ch, bit [11:0] d, bit [1:0] wr, bit [21:0] w,
                        bit [1:0] clr, string tag);
        @(negedge clk);
        res_valid = v; res_chan = ch; res_data = d; cfg_wr = wr; cfg_word = w; flag_clr = clr;
        for (int i = 0; i < 2; i++) begin
            bit set = 0;
            if (wr[i]) begin
                m_en[i] = w[0]; m_cond[i] = w[1]; m_need[i] = w[5:2];
                m_chan[i] = w[9:6]; m_thr[i] = w[21:10]; m_cnt[i] = 0;
            end else if (m_en[i] && v && ch == m_chan[i]) begin
                if (passes(m_cond[i], d, m_thr[i])) begin
                    if (m_cnt[i] == int'(m_need[i])) begin set = 1; m_cnt[i] = 0; end
                    else m_cnt[i]++;
                end else m_cnt[i] = 0;
            end
            if (set) m_flag[i] = 1;
            else if (clr[i]) m_flag[i] = 0;
        end
        @(posedge clk);
        #1;
        check_flags(tag);
    endtask

    task automatic res(bit [3:0] ch, bit [11:0] d, string tag);
        step(1, ch, d, 2'b00, 22'd0, 2'b00, tag);
    endtask

    task automatic wcfg(int i, bit [21:0] w, string tag);
        step(0, 0, 0, 2'(1 << i), w, 2'b00, tag);
    endtask

    task automatic clear(bit [1:0] c, string tag);
        step(0, 0, 0, 2'b00, 22'd0, c, tag);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_flags("R11 reset");
        @(negedge clk); rst_n = 1'b1;
        res(4'd0, 12'd0, "R11 disabled after reset");
        res(4'd0, 12'hFFF, "R11 disabled after reset");

        // R2/R3: N=1, at-or-above, equal value passes
        wcfg(0, mk_cfg(1, 1, 1, 4'd3, 12'h800), "R1 write");
        res(4'd3, 12'h7FF, "R2 below fails ge");
        res(4'd3, 12'h800, "R2 equal passes ge R3 N=1");
        res(4'd3, 12'h000, "R6 sticky");
        clear(2'b10, "R7 zero bit no effect");
        clear(2'b01, "R7 clear");

        // R4: N=3 below, foreign channels and idle cycles ignored
        wcfg(0, mk_cfg(1, 0, 3, 4'd3, 12'h100), "R1 write");
        res(4'd3, 12'h0FF, "R4 hit1");
        res(4'd2, 12'hFFF, "R4 foreign miss");
        step(0, 4'd3, 12'hFFF, 2'b00, 22'd0, 2'b00, "R4 idle");
        res(4'd3, 12'h0FF, "R4 hit2");
        res(4'd7, 12'h000, "R4 foreign hit");
        res(4'd3, 12'h0FF, "R4 hit3 sets");
        clear(2'b01, "R7 clear");

        // R5: miss (equal value under below) restarts run
        res(4'd3, 12'h000, "R5 h");
        res(4'd3, 12'h000, "R5 h");
        res(4'd3, 12'h100, "R5 equal fails lt");
        res(4'd3, 12'h000, "R5 h");
        res(4'd3, 12'h000, "R5 no early flag");
        res(4'd3, 12'h000, "R5 third sets");
        clear(2'b01, "R7 clear");

        // R3: N=16 on instance 1
        wcfg(1, mk_cfg(1, 1, 16, 4'd9, 12'hA00), "R1 write");
        for (int k = 0; k < 15; k++) res(4'd9, 12'hFFF, "R3 N=16 not yet");
        res(4'd9, 12'hA00, "R3 N=16 sets on 16th");
        clear(2'b10, "R7 clear");

        // R6: restart after flag, N=2
        wcfg(0, mk_cfg(1, 1, 2, 4'd1, 12'h010), "R1 write");
        res(4'd1, 12'h010, "R6 h");
        res(4'd1, 12'h020, "R6 sets");
        clear(2'b01, "R7 clear");
        res(4'd1, 12'h020, "R6 restart no flag");
        res(4'd1, 12'h020, "R6 sets again");
        // R7: set and clear together, set wins
        res(4'd1, 12'h020, "R6 h");
        step(1, 4'd1, 12'h020, 2'b00, 22'd0, 2'b01, "R7 set beats clear");
        clear(2'b01, "R7 clear");

        // R8: all-zero word disables; enable=0 with matching fields too
        wcfg(0, 22'd0, "R8 zero word");
        for (int k = 0; k < 3; k++) res(4'd0, 12'h000, "R8 no count");
        wcfg(0, mk_cfg(0, 1, 1, 4'd1, 12'h000), "R8 en low");
        for (int k = 0; k < 3; k++) res(4'd1, 12'h123, "R8 no count");

        // R9: rewrite mid-run restarts; same-cycle result ignored
        wcfg(0, mk_cfg(1, 1, 3, 4'd2, 12'h050), "R1 write");
        res(4'd2, 12'h060, "R9 h");
        res(4'd2, 12'h060, "R9 h");
        step(1, 4'd2, 12'h060, 2'b01, mk_cfg(1, 1, 3, 4'd2, 12'h050), 2'b00, "R9 write with result");
        res(4'd2, 12'h060, "R9 h");
        res(4'd2, 12'h060, "R9 no flag yet");
        res(4'd2, 12'h060, "R9 sets");
        clear(2'b01, "R7 clear");

        // R10: independence
        wcfg(1, mk_cfg(1, 0, 1, 4'd5, 12'h400), "R1 write");
        res(4'd5, 12'h3FF, "R10 only inst1");
        res(4'd2, 12'h060, "R10 inst0 h");
        clear(2'b01, "R10 clear0 keeps flag1");
        res(4'd2, 12'h060, "R10 inst0 h");
        res(4'd2, 12'h060, "R10 inst0 sets");
        clear(2'b11, "R10 clear both");

        // Random stream
        for (int k = 0; k < 4000; k++) begin
            bit [1:0]  wr  = ($urandom_range(0, 40) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            bit [1:0]  clr = ($urandom_range(0, 12) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            bit [21:0] w   = mk_cfg(($urandom_range(0, 7) != 0), 1'($urandom),
                                    $urandom_range(1, 5), 4'($urandom_range(0, 3)),
                                    12'($urandom_range(0, 4095)));
            step(1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 3)),
                 12'($urandom_range(0, 4095)), wr, w, clr, "R3 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule